// File: doc/BRIEF.md
# AC-link Capture Frame Receiver

This block is the controller-side receiver of an AC'97-style serial link. The codec launches one bit on each rising edge of the bit clock. The receiver samples the data line and the frame marker on the falling edge, so it captures each bit half a period after it was launched. A frame opens when the frame marker goes from low to high. The first tag bit follows one bit clock later. The frame then carries a 16-bit tag and twelve 20-bit slots, 256 bits in all, each field sent most significant bit first.

At the end of each complete frame the block publishes four things: the codec-ready flag, the per-slot valid tags, the echoed register address and read data, and the left and right capture samples. A field with its own strobe is updated, and its strobe raised, only when its tag bit is set. If the frame marker rises again before the frame has finished, the partial frame is dropped and a new frame begins.

The control process has four states:
- `ST_IDLE` waits for the marker.
- `ST_TAG` shifts in the tag.
- `ST_SLOT` shifts in slots 1 to 4.
- `ST_PAD` counts through slots 5 to 12.

The named transitions are:
- start: `ST_IDLE` to `ST_TAG` on a marker rise.
- tag_end: `ST_TAG` to `ST_SLOT` after tag bit 0.
- cap_end: `ST_SLOT` to `ST_PAD` after slot 4.
- resync: any receiving state to `ST_TAG` on a marker rise before the last bit.
- frame_end: `ST_PAD` to `ST_IDLE` after the last bit of slot 12.
- chain: `ST_PAD` to `ST_TAG` when the marker rise is sampled together with the last bit.

Top module: `acl_rx_deser`

## Requirements
- R1: A low-to-high change of `sync` seen at a falling edge of `bit_clk` starts a frame. The bit sampled at the next falling edge is tag bit 15.
- R2: A frame is 256 bits: a 16-bit tag followed by twelve 20-bit slots, each sent most significant bit first.
- R3: `frame_stb` is high for exactly one bit clock. It rises at the falling edge that samples bit 256 of a complete frame.
- R4: With `frame_stb`, `codec_ready` takes tag bit 15 and `slot_valid[11:0]` takes tag bits 14:3, so `slot_valid[11]` is the slot 1 tag.
- R5: `reg_addr` takes slot 1 bits 18:12, and `reg_addr_stb` pulses with `frame_stb`, only when tag bit 14 is set.
- R6: `reg_data` takes slot 2 bits 19:4, and `reg_data_stb` pulses with `frame_stb`, only when tag bit 13 is set.
- R7: `pcm_left` takes all 20 bits of slot 3, and `left_stb` pulses with `frame_stb`, only when tag bit 12 is set.
- R8: `pcm_right` takes all 20 bits of slot 4, and `right_stb` pulses with `frame_stb`, only when tag bit 11 is set.
- R9: Every output holds its value between strobes. A data output whose tag bit is clear keeps its old value.
- R10: A `sync` rise before bit 256 of a frame drops that frame without any strobe, and the bit after it is tag bit 15 of a new frame.
- R11: A `sync` rise sampled together with bit 256 completes the current frame and starts the next one with no gap.
- R12: After reset every output is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bit_clk | input | 1 | Serial bit clock; data is sampled on its falling edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| sync | input | 1 | Frame marker; a rising change opens a frame |
| sdata_in | input | 1 | Serial data from the codec |
| frame_stb | output | 1 | One-cycle pulse at the end of each complete frame |
| codec_ready | output | 1 | Tag bit 15 of the last frame |
| slot_valid | output | 12 | Tag bits 14:3 of the last frame |
| reg_addr_stb | output | 1 | Pulse when a returned address is published |
| reg_addr | output | 7 | Returned register address |
| reg_data_stb | output | 1 | Pulse when returned read data is published |
| reg_data | output | 16 | Returned register read data |
| left_stb | output | 1 | Pulse when a left sample is published |
| pcm_left | output | 20 | Left capture sample |
| right_stb | output | 1 | Pulse when a right sample is published |
| pcm_right | output | 20 | Right capture sample |

## Verification
The bench plays the codec and changes `sync` and `sdata_in` on rising edges. Results are due at the falling edge right after the rising edge that launched bit 256, so they are visible at the following rising edge. Each frame task checks `frame_stb` high at exactly that rising edge and low one cycle later. A monitor counts strobes at every rising edge, so a dropped or chained frame shows up as an exact count difference. Field values are compared only after the strobe edge.

// File: rtl/acl_rx_pkg.sv
package acl_rx_pkg;
    typedef enum logic [1:0] {
        ST_IDLE,
        ST_TAG,
        ST_SLOT,
        ST_PAD
    } rx_state_t;
endpackage

// File: rtl/acl_sync_edge.sv
module acl_sync_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic sync,
    output logic rise
);
    logic sync_q;

    always_ff @(negedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= 1'b0;
        else        sync_q <= sync;
    end

    assign rise = sync & ~sync_q;
endmodule

// File: rtl/acl_rx_fsm.sv
module acl_rx_fsm
    import acl_rx_pkg::*;
#(
    parameter int TAG_W  = 16,
    parameter int SLOT_W = 20,
    parameter int NSLOT  = 12,
    parameter int CAP_N  = 4,
    localparam int CW    = $clog2((TAG_W > SLOT_W) ? TAG_W : SLOT_W),
    localparam int SNW   = $clog2(NSLOT + 1)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           rise,
    output logic           shift_en,
    output logic           tag_done,
    output logic           slot_done,
    output logic [SNW-1:0] slot_num,
    output logic           frame_done
);
    rx_state_t      state_q, state_d;
    logic [CW-1:0]  bcnt_q, bcnt_d;
    logic [SNW-1:0] snum_q, snum_d;
    logic           tag_last, slot_last, last_slot;

    assign tag_last  = (bcnt_q == CW'(TAG_W - 1));
    assign slot_last = (bcnt_q == CW'(SLOT_W - 1));
    assign last_slot = (snum_q == SNW'(NSLOT));

    always_ff @(negedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            bcnt_q  <= '0;
            snum_q  <= '0;
        end else begin
            state_q <= state_d;
            bcnt_q  <= bcnt_d;
            snum_q  <= snum_d;
        end
    end

    always_comb begin
        state_d = state_q;
        bcnt_d  = bcnt_q + CW'(1);
        snum_d  = snum_q;
        unique case (state_q)
            ST_IDLE: begin
                bcnt_d = '0;
                if (rise) state_d = ST_TAG;
            end
            ST_TAG: begin
                if (rise) begin
                    bcnt_d = '0;
                end else if (tag_last) begin
                    state_d = ST_SLOT;
                    bcnt_d  = '0;
                    snum_d  = SNW'(1);
                end
            end
            ST_SLOT: begin
                if (rise) begin
                    state_d = ST_TAG;
                    bcnt_d  = '0;
                end else if (slot_last) begin
                    bcnt_d = '0;
                    snum_d = snum_q + SNW'(1);
                    if (snum_q == SNW'(CAP_N)) state_d = ST_PAD;
                end
            end
            ST_PAD: begin
                if (slot_last && last_slot) begin
                    state_d = rise ? ST_TAG : ST_IDLE;
                    bcnt_d  = '0;
                end else if (rise) begin
                    state_d = ST_TAG;
                    bcnt_d  = '0;
                end else if (slot_last) begin
                    bcnt_d = '0;
                    snum_d = snum_q + SNW'(1);
                end
            end
            default: begin
                state_d = ST_IDLE;
                bcnt_d  = '0;
            end
        endcase
    end

    always_comb begin
        shift_en   = (state_q != ST_IDLE);
        tag_done   = (state_q == ST_TAG) && tag_last && !rise;
        slot_done  = (state_q == ST_SLOT) && slot_last && !rise;
        slot_num   = snum_q;
        frame_done = (state_q == ST_PAD) && slot_last && last_slot;
    end
endmodule

// File: rtl/acl_slot_capture.sv
module acl_slot_capture #(
    parameter int TAG_W  = 16,
    parameter int SLOT_W = 20,
    parameter int NSLOT  = 12,
    parameter int ADDR_W = 7,
    parameter int DATA_W = 16,
    localparam int SNW   = $clog2(NSLOT + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sdata,
    input  logic              shift_en,
    input  logic              tag_done,
    input  logic              slot_done,
    input  logic [SNW-1:0]    slot_num,
    input  logic              frame_done,
    output logic              frame_stb,
    output logic              codec_ready,
    output logic [NSLOT-1:0]  slot_valid,
    output logic              reg_addr_stb,
    output logic [ADDR_W-1:0] reg_addr,
    output logic              reg_data_stb,
    output logic [DATA_W-1:0] reg_data,
    output logic              left_stb,
    output logic [SLOT_W-1:0] pcm_left,
    output logic              right_stb,
    output logic [SLOT_W-1:0] pcm_right
);
    logic [SLOT_W-1:0] sh_q, word;
    logic [TAG_W-1:0]  tag_q;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] data_q;
    logic [SLOT_W-1:0] left_q, right_q;

    assign word = {sh_q[SLOT_W-2:0], sdata};

    always_ff @(negedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh_q    <= '0;
            tag_q   <= '0;
            addr_q  <= '0;
            data_q  <= '0;
            left_q  <= '0;
            right_q <= '0;
        end else begin
            if (shift_en) sh_q <= word;
            if (tag_done) tag_q <= word[TAG_W-1:0];
            if (slot_done) begin
                unique case (slot_num)
                    SNW'(1): addr_q  <= word[SLOT_W-2 -: ADDR_W];
                    SNW'(2): data_q  <= word[SLOT_W-1 -: DATA_W];
                    SNW'(3): left_q  <= word;
                    SNW'(4): right_q <= word;
                    default: ;
                endcase
            end
        end
    end

    always_ff @(negedge clk or negedge rst_n) begin
        if (!rst_n) begin
            frame_stb    <= 1'b0;
            codec_ready  <= 1'b0;
            slot_valid   <= '0;
            reg_addr_stb <= 1'b0;
            reg_addr     <= '0;
            reg_data_stb <= 1'b0;
            reg_data     <= '0;
            left_stb     <= 1'b0;
            pcm_left     <= '0;
            right_stb    <= 1'b0;
            pcm_right    <= '0;
        end else begin
            frame_stb    <= frame_done;
            reg_addr_stb <= frame_done && tag_q[TAG_W-2];
            reg_data_stb <= frame_done && tag_q[TAG_W-3];
            left_stb     <= frame_done && tag_q[TAG_W-4];
            right_stb    <= frame_done && tag_q[TAG_W-5];
            if (frame_done) begin
                codec_ready <= tag_q[TAG_W-1];
                slot_valid  <= tag_q[TAG_W-2 -: NSLOT];
                if (tag_q[TAG_W-2]) reg_addr  <= addr_q;
                if (tag_q[TAG_W-3]) reg_data  <= data_q;
                if (tag_q[TAG_W-4]) pcm_left  <= left_q;
                if (tag_q[TAG_W-5]) pcm_right <= right_q;
            end
        end
    end
endmodule

// File: rtl/acl_rx_deser.sv
module acl_rx_deser #(
    parameter int TAG_W  = 16,
    parameter int SLOT_W = 20,
    parameter int NSLOT  = 12,
    parameter int ADDR_W = 7,
    parameter int DATA_W = 16,
    parameter int CAP_N  = 4
) (
    input  logic              bit_clk,
    input  logic              rst_n,
    input  logic              sync,
    input  logic              sdata_in,
    output logic              frame_stb,
    output logic              codec_ready,
    output logic [NSLOT-1:0]  slot_valid,
    output logic              reg_addr_stb,
    output logic [ADDR_W-1:0] reg_addr,
    output logic              reg_data_stb,
    output logic [DATA_W-1:0] reg_data,
    output logic              left_stb,
    output logic [SLOT_W-1:0] pcm_left,
    output logic              right_stb,
    output logic [SLOT_W-1:0] pcm_right
);
    localparam int SNW = $clog2(NSLOT + 1);

    logic           rise, shift_en, tag_done, slot_done, frame_done;
    logic [SNW-1:0] slot_num;

    acl_sync_edge u_edge (
        .clk   (bit_clk),
        .rst_n (rst_n),
        .sync  (sync),
        .rise  (rise)
    );

    acl_rx_fsm #(
        .TAG_W (TAG_W), .SLOT_W (SLOT_W), .NSLOT (NSLOT), .CAP_N (CAP_N)
    ) u_fsm (
        .clk        (bit_clk),
        .rst_n      (rst_n),
        .rise       (rise),
        .shift_en   (shift_en),
        .tag_done   (tag_done),
        .slot_done  (slot_done),
        .slot_num   (slot_num),
        .frame_done (frame_done)
    );

    acl_slot_capture #(
        .TAG_W (TAG_W), .SLOT_W (SLOT_W), .NSLOT (NSLOT),
        .ADDR_W (ADDR_W), .DATA_W (DATA_W)
    ) u_cap (
        .clk          (bit_clk),
        .rst_n        (rst_n),
        .sdata        (sdata_in),
        .shift_en     (shift_en),
        .tag_done     (tag_done),
        .slot_done    (slot_done),
        .slot_num     (slot_num),
        .frame_done   (frame_done),
        .frame_stb    (frame_stb),
        .codec_ready  (codec_ready),
        .slot_valid   (slot_valid),
        .reg_addr_stb (reg_addr_stb),
        .reg_addr     (reg_addr),
        .reg_data_stb (reg_data_stb),
        .reg_data     (reg_data),
        .left_stb     (left_stb),
        .pcm_left     (pcm_left),
        .right_stb    (right_stb),
        .pcm_right    (pcm_right)
    );
endmodule

// File: rtl/acl_rx_chk.sv
module acl_rx_chk #(
    parameter int NSLOT  = 12,
    parameter int ADDR_W = 7,
    parameter int DATA_W = 16,
    parameter int SLOT_W = 20,
    parameter int TAG_W  = 16
) (
    input logic              bit_clk,
    input logic              rst_n,
    input logic              frame_stb,
    input logic              codec_ready,
    input logic [NSLOT-1:0]  slot_valid,
    input logic              reg_addr_stb,
    input logic [ADDR_W-1:0] reg_addr,
    input logic              reg_data_stb,
    input logic [DATA_W-1:0] reg_data,
    input logic              left_stb,
    input logic [SLOT_W-1:0] pcm_left,
    input logic              right_stb,
    input logic [SLOT_W-1:0] pcm_right
);
    localparam int FRAME_W = TAG_W + NSLOT * SLOT_W;
    localparam int GW      = $clog2(FRAME_W + 1);

    logic [GW-1:0] gap_q;
    logic          seen_q;

    always_ff @(negedge bit_clk or negedge rst_n) begin
        if (!rst_n) begin
            gap_q  <= '0;
            seen_q <= 1'b0;
        end else if (frame_stb) begin
            gap_q  <= '0;
            seen_q <= 1'b1;
        end else if (gap_q != GW'(FRAME_W)) begin
            gap_q <= gap_q + GW'(1);
        end
    end

    // R3
    stb_width_chk: assert property (@(negedge bit_clk) disable iff (!rst_n)
        frame_stb |=> !frame_stb);

    // R3
    frame_gap_chk: assert property (@(negedge bit_clk) disable iff (!rst_n)
        (frame_stb && seen_q) |-> (gap_q >= GW'(FRAME_W - 1)));

    // R5
    addr_tag_chk: assert property (@(negedge bit_clk) disable iff (!rst_n)
        reg_addr_stb |-> (frame_stb && slot_valid[NSLOT-1]));

    // R6
    data_tag_chk: assert property (@(negedge bit_clk) disable iff (!rst_n)
        reg_data_stb |-> (frame_stb && slot_valid[NSLOT-2]));

    // R7
    left_tag_chk: assert property (@(negedge bit_clk) disable iff (!rst_n)
        frame_stb |-> (left_stb == slot_valid[NSLOT-3]));

    // R8
    right_tag_chk: assert property (@(negedge bit_clk) disable iff (!rst_n)
        frame_stb |-> (right_stb == slot_valid[NSLOT-4]));

    // R9
    hold_tag_chk: assert property (@(negedge bit_clk) disable iff (!rst_n)
        !frame_stb |-> ($stable(codec_ready) && $stable(slot_valid)));

    // R9
    hold_pcm_chk: assert property (@(negedge bit_clk) disable iff (!rst_n)
        (!left_stb && !right_stb) |-> ($stable(pcm_left) && $stable(pcm_right)));

    // R9
    hold_reg_chk: assert property (@(negedge bit_clk) disable iff (!rst_n)
        (!reg_addr_stb && !reg_data_stb) |-> ($stable(reg_addr) && $stable(reg_data)));
endmodule

bind acl_rx_deser acl_rx_chk #(
    .NSLOT (NSLOT), .ADDR_W (ADDR_W), .DATA_W (DATA_W), .SLOT_W (SLOT_W), .TAG_W (TAG_W)
) u_chk (
    .bit_clk      (bit_clk),
    .rst_n        (rst_n),
    .frame_stb    (frame_stb),
    .codec_ready  (codec_ready),
    .slot_valid   (slot_valid),
    .reg_addr_stb (reg_addr_stb),
    .reg_addr     (reg_addr),
    .reg_data_stb (reg_data_stb),
    .reg_data     (reg_data),
    .left_stb     (left_stb),
    .pcm_left     (pcm_left),
    .right_stb    (right_stb),
    .pcm_right    (pcm_right)
);

// File: tb/sim_acl_rx_deser.sv
module sim_acl_rx_deser;
    logic clk = 1'b0, rst_n = 1'b0, sync = 1'b0, sdata = 1'b0;
    logic        frame_stb, codec_ready, reg_addr_stb, reg_data_stb, left_stb, right_stb;
    logic [11:0] slot_valid;
    logic [6:0]  reg_addr;
    logic [15:0] reg_data;
    logic [19:0] pcm_left, pcm_right;

    int checks = 0, errors = 0;
    int n_frame = 0, n_addr = 0, n_data = 0, n_left = 0, n_right = 0;

    always #4 clk = ~clk;

    acl_rx_deser u0 (
        .bit_clk (clk), .rst_n (rst_n), .sync (sync), .sdata_in (sdata),
        .frame_stb (frame_stb), .codec_ready (codec_ready), .slot_valid (slot_valid),
        .reg_addr_stb (reg_addr_stb), .reg_addr (reg_addr),
        .reg_data_stb (reg_data_stb), .reg_data (reg_data),
        .left_stb (left_stb), .pcm_left (pcm_left),
        .right_stb (right_stb), .pcm_right (pcm_right)
    );

    always @(posedge clk) begin
        if (rst_n) begin
            if (frame_stb)    n_frame++;
            if (reg_addr_stb) n_addr++;
            if (reg_data_stb) n_data++;
            if (left_stb)     n_left++;
            if (right_stb)    n_right++;
        end
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [255:0] mk(input logic [15:0] tag, input logic [6:0] a,
                                        input logic [15:0] d, input logic [19:0] l,
                                        input logic [19:0] r);
        return {tag, 1'b0, a, 12'h000, d, 4'h0, l, r, 160'd0};
    endfunction

    task automatic drive(input logic [255:0] f, input int nbits, input bit rise_first, input bit rise_end);
        if (rise_first) begin
            @(posedge clk);
            sync  <= 1'b1;
            sdata <= 1'b0;
        end
        for (int i = 0; i < nbits; i++) begin
            @(posedge clk);
            sdata <= f[255-i];
            sync  <= (i < 15) || (rise_end && i == nbits - 1);
        end
    endtask

    task automatic close_frame(input string req);
        @(posedge clk);
        sync  <= 1'b0;
        sdata <= 1'b0;
        #1 chk(frame_stb === 1'b1, req, 32'(frame_stb), 32'd1);
        @(posedge clk);
        #1 chk(frame_stb === 1'b0, req, 32'(frame_stb), 32'd0);
    endtask

    task automatic t_reset;
        chk(frame_stb === 1'b0 && reg_addr_stb === 1'b0 && left_stb === 1'b0 && right_stb === 1'b0,
            "R12 strobes", 32'({frame_stb, reg_addr_stb, left_stb, right_stb}), 32'd0);
        chk(codec_ready === 1'b0 && slot_valid === 12'd0, "R12 tag outs",
            32'({codec_ready, slot_valid}), 32'd0);
        chk(pcm_left === 20'd0 && pcm_right === 20'd0 && reg_data === 16'd0 && reg_addr === 7'd0,
            "R12 data outs", 32'(pcm_left | pcm_right), 32'd0);
    endtask

    task automatic t_full;
        int f0 = n_frame, a0 = n_addr, d0 = n_data, l0 = n_left, r0 = n_right;
        drive(mk(16'hF800, 7'h2A, 16'hBEEF, 20'h80001, 20'h5A5A5), 256, 1'b1, 1'b0);
        close_frame("R3 strobe timing full");
        chk(codec_ready === 1'b1, "R1 R4 codec_ready", 32'(codec_ready), 32'd1);
        chk(slot_valid === 12'hF00, "R4 slot_valid", 32'(slot_valid), 32'hF00);
        chk(reg_addr === 7'h2A, "R5 reg_addr", 32'(reg_addr), 32'h2A);
        chk(reg_data === 16'hBEEF, "R6 reg_data", 32'(reg_data), 32'hBEEF);
        chk(pcm_left === 20'h80001, "R2 R7 pcm_left msb first", 32'(pcm_left), 32'h80001);
        chk(pcm_right === 20'h5A5A5, "R8 pcm_right", 32'(pcm_right), 32'h5A5A5);
        chk((n_frame - f0) == 1 && (n_addr - a0) == 1 && (n_data - d0) == 1 &&
            (n_left - l0) == 1 && (n_right - r0) == 1, "R3 one pulse each",
            32'(n_frame - f0), 32'd1);
    endtask

    task automatic t_right_only;
        int l0 = n_left, r0 = n_right, a0 = n_addr;
        drive(mk(16'h8800, 7'h11, 16'h1234, 20'h33333, 20'h0F0F1), 256, 1'b1, 1'b0);
        close_frame("R3 strobe timing right");
        chk(pcm_right === 20'h0F0F1 && (n_right - r0) == 1, "R8 right only",
            32'(pcm_right), 32'h0F0F1);
        chk(pcm_left === 20'h80001 && (n_left - l0) == 0, "R9 left held", 32'(pcm_left), 32'h80001);
        chk(reg_addr === 7'h2A && reg_data === 16'hBEEF && (n_addr - a0) == 0, "R9 reg held",
            32'(reg_addr), 32'h2A);
        chk(slot_valid === 12'h100, "R4 slot_valid right", 32'(slot_valid), 32'h100);
    endtask

    task automatic t_not_ready;
        int f0 = n_frame, r0 = n_right;
        drive(mk(16'h0000, 7'h7F, 16'hFFFF, 20'hFFFFF, 20'hFFFFF), 256, 1'b1, 1'b0);
        close_frame("R3 strobe timing idle tag");
        chk(codec_ready === 1'b0 && slot_valid === 12'd0, "R4 not ready",
            32'({codec_ready, slot_valid}), 32'd0);
        chk(pcm_right === 20'h0F0F1 && (n_right - r0) == 0 && (n_frame - f0) == 1,
            "R9 no tag no update", 32'(pcm_right), 32'h0F0F1);
    endtask

    task automatic t_abort;
        int f0 = n_frame, l0 = n_left;
        drive(mk(16'hF800, 7'h01, 16'h0001, 20'h00001, 20'h00001), 100, 1'b1, 1'b1);
        drive(mk(16'hF000, 7'h55, 16'hA5A5, 20'hC0FFE, 20'h00000), 256, 1'b0, 1'b0);
        close_frame("R10 strobe after resync");
        chk((n_frame - f0) == 1, "R10 partial dropped", 32'(n_frame - f0), 32'd1);
        chk((n_left - l0) == 1 && pcm_left === 20'hC0FFE, "R10 new frame left",
            32'(pcm_left), 32'hC0FFE);
        chk(reg_addr === 7'h55 && reg_data === 16'hA5A5, "R10 new frame reg",
            32'(reg_data), 32'hA5A5);
    endtask

    task automatic t_chain;
        int f0 = n_frame, r0 = n_right;
        drive(mk(16'h8800, 7'h00, 16'h0000, 20'h00000, 20'h12345), 256, 1'b1, 1'b1);
        drive(mk(16'h8800, 7'h00, 16'h0000, 20'h00000, 20'h6789A), 256, 1'b0, 1'b0);
        close_frame("R11 strobe second frame");
        chk((n_frame - f0) == 2 && (n_right - r0) == 2, "R11 both frames",
            32'(n_frame - f0), 32'd2);
        chk(pcm_right === 20'h6789A, "R11 second value", 32'(pcm_right), 32'h6789A);
    endtask

    initial begin
        #(8 * 200000);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 t_reset;
        rst_n = 1'b1;
        repeat (2) @(posedge clk);
        t_full;
        t_right_only;
        t_not_ready;
        t_abort;
        t_chain;
        repeat (4) @(posedge clk);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule